// File: doc/BRIEF.md
# Car Park Occupancy Tracker

This block counts vehicles in a car park from two sensor lines, one at the entrance barrier and one at the exit barrier, and lights a "lot full" indicator. Each raw sensor line is brought into the clock domain and reduced to a single-cycle event per vehicle. Every entry event advances a 12-bit occupancy count. When that count rolls over from all ones to zero, the most significant bit falls. That fall, seen inside the clock domain, sets a held full flag. Any exit event drops the flag again.

A mode input chooses between two schemes. In the plain scheme an exit only drops the flag and leaves the count alone. In the tracking scheme an exit also takes one off the count, so the count follows net occupancy. When the flag is set, a count of zero stands for a full lot, so a tracking-mode exit at that point rolls the count back to 4095. An asynchronous active-low reset and a synchronous clear both return the block to empty.

Top module: `lot_occupancy_monitor`

## Requirements
- R1: While `rst_n` is low, `occupancy` reads 0 and `lot_full` reads 0.
- R2: A `clr` level sampled high at a clock edge sets `occupancy` to 0 and `lot_full` to 0 at that edge. This holds even when the flag was set.
- R3: A high level on `entry_raw` of any length produces exactly one count step. The new count shows three clock edges after the first edge that samples the high level (two synchroniser stages, then the counter register).
- R4: `lot_full` rises one edge after the edge at which the count rolls from 4095 to 0 (the MSB falls to a zero count). An MSB fall caused by a decrement from 2048 to 2047 does not set the flag.
- R5: Once set, `lot_full` stays high through further entry events until an exit event or a clear.
- R6: An exit event clears `lot_full` in both modes, at the same edge that updates the count. If an MSB-fall set and an exit coincide, the clear wins.
- R7: With `track_mode` = 0, an exit event leaves `occupancy` unchanged. A simultaneous entry and exit advance it by one.
- R8: With `track_mode` = 1, an exit event alone decrements `occupancy` by one.
- R9: With `track_mode` = 1, simultaneous entry and exit events leave `occupancy` unchanged.
- R10: With `track_mode` = 1, an exit at a count of 0 behaves in one of two ways. If `lot_full` is 0, the count stays at 0. If `lot_full` is 1, the count becomes 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of count and flag |
| entry_raw | input | 1 | Raw entrance sensor level, asynchronous |
| exit_raw | input | 1 | Raw exit sensor level, asynchronous |
| track_mode | input | 1 | 0 = plain scheme, 1 = exits decrement the count |
| occupancy | output | 12 | Vehicle count |
| lot_full | output | 1 | Held full indicator |

## Verification
The hardest state to reach is the roll-over itself, because it takes 4096 separate entry events through the synchroniser before the MSB falls. The stimulus uses a fast burst that pulses the entrance line every second cycle to approach the roll-over. It then sends the final vehicle one edge at a time, so the bench can show that the count is zero one edge before the flag rises. A second burst to 2048 followed by a tracking-mode exit drives the MSB down through a decrement, which must not set the flag. The exit right after the roll-over covers the case where a zero count with the flag set must roll back to 4095.

// File: rtl/occ_pkg.sv
package occ_pkg;
  localparam int OCC_CNT_W   = 12;
  localparam int OCC_SYNC_ST = 2;

  typedef enum logic {
    SCHEME_PLAIN = 1'b0,
    SCHEME_TRACK = 1'b1
  } scheme_e;
endpackage

// File: rtl/occ_sensor_edge.sv
module occ_sensor_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic evt
);
  logic [STAGES:0] chain_q;
  logic [STAGES:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-1:0], raw};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  // one-cycle pulse on the synchronised rising level
  assign evt = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/occ_counter.sv
module occ_counter
  import occ_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ent,
  input  logic             ext,
  input  scheme_e          scheme,
  input  logic             full,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = 1'b0;
    if (clr) begin
      cnt_d  = '0;
      cnt_en = 1'b1;
    end else begin
      unique case ({ent, ext})
        2'b10: begin
          cnt_d  = cnt_q + 1'b1;
          cnt_en = 1'b1;
        end
        2'b01: begin
          // a zero count with the flag set stands for a full lot
          if (scheme == SCHEME_TRACK && (cnt_q != '0 || full)) begin
            cnt_d  = cnt_q - 1'b1;
            cnt_en = 1'b1;
          end
        end
        2'b11: begin
          if (scheme == SCHEME_PLAIN) begin
            cnt_d  = cnt_q + 1'b1;
            cnt_en = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/occ_full_flag.sv
module occ_full_flag #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ext,
  input  logic [CNT_W-1:0] cnt,
  output logic             full
);
  localparam int MSB = CNT_W - 1;

  logic msb_q;
  logic full_q;
  logic full_d;
  logic roll;

  // MSB fell and landed on zero: roll-over, not a decrement
  assign roll = msb_q & ~cnt[MSB] & ~|cnt;

  always_comb begin
    full_d = full_q;
    if (roll) full_d = 1'b1;
    if (ext)  full_d = 1'b0;
    if (clr)  full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msb_q  <= 1'b0;
      full_q <= 1'b0;
    end else begin
      msb_q  <= clr ? 1'b0 : cnt[MSB];
      full_q <= full_d;
    end
  end

  assign full = full_q;
endmodule

// File: rtl/lot_occupancy_monitor.sv
module lot_occupancy_monitor
  import occ_pkg::*;
#(
  parameter int CNT_W     = OCC_CNT_W,
  parameter int SYNC_ST   = OCC_SYNC_ST
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             entry_raw,
  input  logic             exit_raw,
  input  logic             track_mode,
  output logic [CNT_W-1:0] occupancy,
  output logic             lot_full
);
  logic    entry_evt;
  logic    exit_evt;
  scheme_e scheme;

  assign scheme = scheme_e'(track_mode);

  occ_sensor_edge #(.STAGES(SYNC_ST)) u_entry (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (entry_raw),
    .evt   (entry_evt)
  );

  occ_sensor_edge #(.STAGES(SYNC_ST)) u_exit (
    .clk   (clk),
    .rst_n (rst_n),
    .raw   (exit_raw),
    .evt   (exit_evt)
  );

  occ_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr),
    .ent    (entry_evt),
    .ext    (exit_evt),
    .scheme (scheme),
    .full   (lot_full),
    .cnt    (occupancy)
  );

  occ_full_flag #(.CNT_W(CNT_W)) u_flag (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .ext   (exit_evt),
    .cnt   (occupancy),
    .full  (lot_full)
  );
endmodule

// File: rtl/occ_checker.sv
module occ_checker #(
  parameter int CNT_W = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr,
  input logic             track_mode,
  input logic [CNT_W-1:0] occupancy,
  input logic             lot_full,
  input logic             entry_evt,
  input logic             exit_evt
);
  localparam int MSB = CNT_W - 1;

  logic [CNT_W-1:0] prev_q;
  logic [CNT_W-1:0] delta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= occupancy;
  end

  assign delta = occupancy - prev_q;

  // R1
  always_comb begin
    if (!rst_n) reset_state_chk: assert (occupancy == '0 && !lot_full);
  end

  // R2
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> (occupancy == '0 && !lot_full));

  // R3
  single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(clr) |-> (delta == '0 || delta == 1 || delta == '1));

  // R4
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lot_full) |-> ($past(occupancy[MSB], 2) && $past(occupancy) == '0));

  // R5
  flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lot_full) |-> ($past(exit_evt) || $past(clr)));

  // R6
  exit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(exit_evt) |-> !lot_full);

  // R7
  plain_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!track_mode && !clr && !entry_evt) |-> $stable(occupancy));

  // R9
  both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(track_mode && !clr && entry_evt && exit_evt) |-> $stable(occupancy));
endmodule

bind lot_occupancy_monitor occ_checker #(.CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr        (clr),
  .track_mode (track_mode),
  .occupancy  (occupancy),
  .lot_full   (lot_full),
  .entry_evt  (entry_evt),
  .exit_evt   (exit_evt)
);

// File: tb/sim_lot_occupancy_monitor.sv
`timescale 1ns/1ps
module sim_lot_occupancy_monitor;
  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         clr;
  logic         entry_raw;
  logic         exit_raw;
  logic         track_mode;
  logic [W-1:0] occupancy;
  logic         lot_full;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  lot_occupancy_monitor u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (clr),
    .entry_raw  (entry_raw),
    .exit_raw   (exit_raw),
    .track_mode (track_mode),
    .occupancy  (occupancy),
    .lot_full   (lot_full)
  );

  // {entry, exit, mode, exp_full, exp_count[11:0]}
  localparam int NV = 12;
  localparam logic [15:0] VEC [NV] = '{
    16'hA001,  // R3 R8 entry
    16'hA002,  // R3 entry
    16'h8003,  // R7 plain entry
    16'h6002,  // R8 tracking exit
    16'hE002,  // R9 both, tracking
    16'h4002,  // R7 plain exit
    16'hC003,  // R7 both, plain
    16'h6002,  // R8
    16'h6001,  // R8
    16'h6000,  // R8
    16'h6000,  // R10 exit at zero, flag clear
    16'hA001   // R3
  };

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic drive_evt(input logic e, input logic x, input logic m);
    @(negedge clk);
    entry_raw = e; exit_raw = x; track_mode = m;
    @(negedge clk);
    entry_raw = 1'b0; exit_raw = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic burst(input int n, input logic m);
    track_mode = m;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); entry_raw = 1'b1;
      @(negedge clk); entry_raw = 1'b0;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic pulse_clr();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; clr = 1'b0; entry_raw = 1'b0; exit_raw = 1'b0; track_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 count in reset", occupancy, 0);
    chk("R1 flag in reset", lot_full, 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      drive_evt(VEC[v][15], VEC[v][14], VEC[v][13]);
      chk($sformatf("R3/R7-R10 vector %0d count", v), occupancy, VEC[v][11:0]);
      chk($sformatf("R6 vector %0d flag", v), lot_full, VEC[v][12]);
    end

    // R3 long level gives one step
    @(negedge clk); entry_raw = 1'b1; track_mode = 1'b1;
    repeat (6) @(negedge clk);
    entry_raw = 1'b0;
    repeat (3) @(negedge clk);
    chk("R3 long level one step", occupancy, 2);

    pulse_clr();
    chk("R2 clear count", occupancy, 0);

    // R4 decrement through the midpoint does not set the flag
    burst(2048, 1'b1);
    chk("R4 midpoint count", occupancy, 2048);
    drive_evt(1'b0, 1'b1, 1'b1);
    chk("R4 midpoint decrement count", occupancy, 2047);
    chk("R4 midpoint no flag", lot_full, 0);

    // R4 exact roll-over timing, tracking mode
    pulse_clr();
    burst(4095, 1'b1);
    chk("R4 count before last car", occupancy, 4095);
    chk("R4 flag before last car", lot_full, 0);
    @(negedge clk); entry_raw = 1'b1;
    @(negedge clk); entry_raw = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R4 count rolled", occupancy, 0);
    chk("R4 flag not yet", lot_full, 0);
    @(negedge clk);
    chk("R4 flag one edge after roll", lot_full, 1);
    drive_evt(1'b0, 1'b1, 1'b1);
    chk("R6 exit clears flag", lot_full, 0);
    chk("R10 exit at zero with flag", occupancy, 4095);

    // R5 and R7 in plain mode
    pulse_clr();
    burst(4096, 1'b0);
    chk("R4 plain roll count", occupancy, 0);
    chk("R4 plain roll flag", lot_full, 1);
    burst(2, 1'b0);
    chk("R5 flag held over entries", lot_full, 1);
    chk("R5 count after entries", occupancy, 2);
    drive_evt(1'b0, 1'b1, 1'b0);
    chk("R6 plain exit clears flag", lot_full, 0);
    chk("R7 plain exit keeps count", occupancy, 2);

    // R2 clear with flag set
    burst(4094, 1'b0);
    chk("R5 flag set again", lot_full, 1);
    pulse_clr();
    chk("R2 clear flag", lot_full, 0);
    chk("R2 clear count after roll", occupancy, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule